// File: doc/BRIEF.md
# Bus Command Sequencer with Accumulator

This block is a small programmable controller that drives a Wishbone classic bus as its only master. It steps through a short list of 32-bit command words held in an internal program store and turns each one into a bus write, a bus read, a timed pause or a hand-off of data to a host. It is meant for bring-up and configuration work: a fixed list of register writes, a status read, a copy of that value to another address, and a report of the value to a supervising controller.

The block has no arithmetic or compare logic. A single 32-bit accumulator is its only data register. Instructions run strictly in order. After the last program slot, execution goes back to slot zero and repeats indefinitely.

The program is written through a load port that accepts one word per cycle. That port never stalls. The usual flow is to fill the store while reset is held and then release reset. Results leave on a host output that uses a valid/ready handshake. The host can hold off the sequencer by keeping its ready input low.

Top module: `cseq_top`

## Requirements
- R1: The top 4 bits of a command word hold the opcode and the low 28 bits hold the immediate. The opcodes are 0x0 no-op, 0x1 write immediate, 0x2 read into accumulator, 0x3 write accumulator, 0x4 hand accumulator to host and 0x8 pause. Every other opcode acts as a no-op. A no-op takes exactly one cycle.
- R2: While reset is low, `wb_cyc_o`, `wb_stb_o` and `host_valid_o` are 0. The program counter and the accumulator clear to zero, so the first command executed after reset is slot 0 and the accumulator reads 0.
- R3: Opcode 0x1 uses the next program word as the full 32-bit bus address. It writes the immediate, zero-extended to 32 bits, with `wb_we_o` = 1.
- R4: Opcode 0x2 uses the next program word as the address and performs a bus read with `wb_we_o` = 0. It loads `wb_dat_i` into the accumulator in the cycle where `wb_ack_i` is high.
- R5: Opcode 0x3 uses the next program word as the address and writes the current accumulator value. Its immediate is ignored.
- R6: Opcode 0x4 raises `host_valid_o` with `host_data_o` equal to the accumulator. Both hold until `host_ready_i` is seen high, then valid drops on the next cycle. When ready is already high, valid is high for exactly one cycle.
- R7: Opcode 0x8 with count N stalls for N cycles. If the previous access was acknowledged in cycle t and the pause is followed by a bus command, the next `wb_cyc_o` rises in cycle t+4+N.
- R8: `wb_cyc_o` and `wb_stb_o` rise together and stay high with stable address, data and write enable until `wb_ack_i`. They drop in the cycle after the acknowledge. No new command starts before that. Two bus commands in a row start 3 cycles apart, measured from acknowledge to the next rise.
- R9: Commands execute in program order. A two-word command advances the program counter past its address word. After the last slot the counter wraps to slot 0.
- R10: `prog_ready_o` is always 1. A word presented with `prog_valid_i` is stored at `prog_addr_i` at the next clock edge, including while reset is held. The sequencer uses it the next time that slot is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_valid_i | input | 1 | Program word present on the load port |
| prog_ready_o | output | 1 | Load port ready (always 1) |
| prog_addr_i | input | PC_W | Program slot to write |
| prog_data_i | input | 32 | Program word to write |
| wb_adr_o | output | 32 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_ack_i | input | 1 | Bus acknowledge |
| host_data_o | output | 32 | Accumulator value offered to the host |
| host_valid_o | output | 1 | Host data valid |
| host_ready_i | input | 1 | Host accepts data |

## Verification
A directed program uses every opcode once, including two unassigned ones. It runs for two full passes under random acknowledge delays and random host back-pressure. This tells apart the immediate, read, accumulator-write and host paths, and shows that the accumulator carries its value across the wrap. A second directed program runs with zero-latency acknowledges. It measures the cycle gaps between accesses for back-to-back commands, pauses of 0, 1 and 25 cycles, and a run of no-ops before the wrap, which pins down the cycle cost of each command. Random programs with random bus latency and ready patterns are then checked against a bench interpreter. They catch ordering and accumulator errors that the fixed programs cannot reach.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned IMM_W  = WORD_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'h0,
    OP_WR_IMM = 4'h1,
    OP_RD_ACC = 4'h2,
    OP_WR_ACC = 4'h3,
    OP_HOST   = 4'h4,
    OP_DELAY  = 4'h8
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_ADDR,
    ST_BUS,
    ST_DELAY,
    ST_HOST
  } st_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [IMM_W-1:0] imm;
  } instr_t;
endpackage

// File: rtl/cseq_progmem.sv
module cseq_progmem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned WW    = 32
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [WW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [WW-1:0] rd_data_o
);
  logic [WW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (32'(wr_addr_i) == g)) begin
        mem_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/cseq_busport.sv
module cseq_busport #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [DW-1:0] adr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] wb_adr_o,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  input  logic          wb_ack_i
);
  logic          active_q;
  logic          we_q;
  logic [DW-1:0] adr_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      we_q     <= 1'b0;
      adr_q    <= '0;
      dat_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      we_q     <= we_i;
      adr_q    <= adr_i;
      dat_q    <= wdata_i;
    end else if (active_q && wb_ack_i) begin
      active_q <= 1'b0;
    end
  end

  assign wb_cyc_o = active_q;
  assign wb_stb_o = active_q;
  assign wb_we_o  = we_q;
  assign wb_adr_o = adr_q;
  assign wb_dat_o = dat_q;
  assign done_o   = active_q & wb_ack_i;
  assign rdata_o  = wb_dat_i;
endmodule

// File: rtl/cseq_waitctr.sv
module cseq_waitctr #(
  parameter int unsigned CW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= count_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/cseq_hostport.sv
module cseq_hostport #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o,
  output logic [DW-1:0] host_data_o,
  output logic          host_valid_o,
  input  logic          host_ready_i
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (start_i && !valid_q) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (valid_q && host_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign host_valid_o = valid_q;
  assign host_data_o  = data_q;
  assign done_o       = valid_q & host_ready_i;
endmodule

// File: rtl/cseq_top.sv
module cseq_top
  import cseq_pkg::*;
#(
  parameter int unsigned PROG_DEPTH = 16,
  localparam int unsigned PC_W = $clog2(PROG_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_valid_i,
  output logic              prog_ready_o,
  input  logic [PC_W-1:0]   prog_addr_i,
  input  logic [WORD_W-1:0] prog_data_i,
  output logic [WORD_W-1:0] wb_adr_o,
  output logic [WORD_W-1:0] wb_dat_o,
  input  logic [WORD_W-1:0] wb_dat_i,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  input  logic              wb_ack_i,
  output logic [WORD_W-1:0] host_data_o,
  output logic              host_valid_o,
  input  logic              host_ready_i
);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PROG_DEPTH - 1);

  st_e               state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d, pc_inc;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [IMM_W-1:0]  imm_q, imm_d;
  logic [WORD_W-1:0] cur_word;
  instr_t            cur;

  logic              bus_start, bus_done, bus_we;
  logic [WORD_W-1:0] bus_wdata, bus_rdata;
  logic              delay_load, delay_last;
  logic              host_start, host_done;

  assign prog_ready_o = 1'b1;

  cseq_progmem #(
    .DEPTH (PROG_DEPTH),
    .AW    (PC_W),
    .WW    (WORD_W)
  ) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (prog_valid_i),
    .wr_addr_i (prog_addr_i),
    .wr_data_i (prog_data_i),
    .rd_addr_i (pc_q),
    .rd_data_o (cur_word)
  );

  assign cur    = instr_t'(cur_word);
  assign pc_inc = (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;

  assign bus_we    = (op_q != OP_RD_ACC);
  assign bus_wdata = (op_q == OP_WR_IMM) ? {{OP_W{1'b0}}, imm_q} : acc_q;

  cseq_busport #(.DW(WORD_W)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (bus_start),
    .we_i     (bus_we),
    .adr_i    (cur_word),
    .wdata_i  (bus_wdata),
    .done_o   (bus_done),
    .rdata_o  (bus_rdata),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_dat_i (wb_dat_i),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_ack_i (wb_ack_i)
  );

  cseq_waitctr #(.CW(IMM_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (delay_load),
    .count_i (cur.imm),
    .last_o  (delay_last)
  );

  cseq_hostport #(.DW(WORD_W)) u_host (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (host_start),
    .data_i       (acc_q),
    .done_o       (host_done),
    .host_data_o  (host_data_o),
    .host_valid_o (host_valid_o),
    .host_ready_i (host_ready_i)
  );

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    acc_d      = acc_q;
    op_d       = op_q;
    imm_d      = imm_q;
    bus_start  = 1'b0;
    delay_load = 1'b0;
    host_start = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        pc_d = pc_inc;
        case (cur.op)
          OP_WR_IMM, OP_RD_ACC, OP_WR_ACC: begin
            op_d    = cur.op;
            imm_d   = cur.imm;
            state_d = ST_ADDR;
          end
          OP_HOST: begin
            host_start = 1'b1;
            state_d    = ST_HOST;
          end
          OP_DELAY: begin
            if (cur.imm != '0) begin
              delay_load = 1'b1;
              state_d    = ST_DELAY;
            end
          end
          default: ;
        endcase
      end
      ST_ADDR: begin
        pc_d      = pc_inc;
        bus_start = 1'b1;
        state_d   = ST_BUS;
      end
      ST_BUS: begin
        if (bus_done) begin
          if (op_q == OP_RD_ACC) acc_d = bus_rdata;
          state_d = ST_FETCH;
        end
      end
      ST_DELAY: begin
        if (delay_last) state_d = ST_FETCH;
      end
      ST_HOST: begin
        if (host_done) state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      acc_q   <= '0;
      op_q    <= OP_NOP;
      imm_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      acc_q   <= acc_d;
      op_q    <= op_d;
      imm_q   <= imm_d;
    end
  end
endmodule

// File: rtl/cseq_chk.sv
module cseq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] wb_adr_o,
  input logic [31:0] wb_dat_o,
  input logic        wb_cyc_o,
  input logic        wb_stb_o,
  input logic        wb_we_o,
  input logic        wb_ack_i,
  input logic [31:0] host_data_o,
  input logic        host_valid_o,
  input logic        host_ready_i
);
  p_reset_idle_r2: assert property (@(posedge clk_i)
    !rst_ni |=> (!wb_cyc_o && !wb_stb_o && !host_valid_o));

  p_cyc_stb_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cyc_o == wb_stb_o);

  p_bus_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && !wb_ack_i) |=>
      (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o)));

  p_bus_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

  p_host_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_o && !host_ready_i) |=> (host_valid_o && $stable(host_data_o)));

  p_host_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_o && host_ready_i) |=> !host_valid_o);

  p_one_at_a_time_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_cyc_o && host_valid_o));
endmodule

bind cseq_top cseq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wb_adr_o     (wb_adr_o),
  .wb_dat_o     (wb_dat_o),
  .wb_cyc_o     (wb_cyc_o),
  .wb_stb_o     (wb_stb_o),
  .wb_we_o      (wb_we_o),
  .wb_ack_i     (wb_ack_i),
  .host_data_o  (host_data_o),
  .host_valid_o (host_valid_o),
  .host_ready_i (host_ready_i)
);

// File: tb/cseq_top_tb_top.sv
`timescale 1ns/1ps
module cseq_top_tb_top;
  localparam int DEPTH = 16;
  localparam int PCW   = 4;
  localparam int MAXEV = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            prog_valid_i = 1'b0;
  logic            prog_ready_o;
  logic [PCW-1:0]  prog_addr_i = '0;
  logic [31:0]     prog_data_i = '0;
  logic [31:0]     wb_adr_o, wb_dat_o, wb_dat_i;
  logic            wb_cyc_o, wb_stb_o, wb_we_o;
  logic            wb_ack_i = 1'b0;
  logic [31:0]     host_data_o;
  logic            host_valid_o;
  logic            host_ready_i = 1'b0;

  always #10 clk_i = ~clk_i;

  cseq_top #(.PROG_DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .prog_valid_i, .prog_ready_o, .prog_addr_i, .prog_data_i,
    .wb_adr_o, .wb_dat_o, .wb_dat_i, .wb_cyc_o, .wb_stb_o, .wb_we_o, .wb_ack_i,
    .host_data_o, .host_valid_o, .host_ready_i
  );

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16]};
  endfunction
  assign wb_dat_i = rd_fn(wb_adr_o);

  int n_tests = 0, n_fail = 0, cyc_cnt = 0;
  bit done = 0;
  int ack_lat_max = 0, ready_pct = 100;
  bit in_acc = 0;
  int lat = 0, wait_n = 0, cur_rise = 0;
  logic [31:0] prog [DEPTH];

  int ob_n = 0;
  int ob_kind [MAXEV];
  logic [31:0] ob_adr [MAXEV], ob_dat [MAXEV];
  int ob_rise [MAXEV], ob_ack [MAXEV];

  int ex_n = 0;
  int ex_kind [MAXEV];
  logic [31:0] ex_adr [MAXEV], ex_dat [MAXEV];
  string ex_tag [MAXEV];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void record(input int k, input logic [31:0] a, input logic [31:0] d,
                                 input int r, input int c);
    if (ob_n < MAXEV) begin
      ob_kind[ob_n] = k; ob_adr[ob_n] = a; ob_dat[ob_n] = d;
      ob_rise[ob_n] = r; ob_ack[ob_n] = c;
      ob_n++;
    end
  endfunction

  function automatic void push(input int k, input logic [31:0] a, input logic [31:0] d,
                               input string t);
    if (ex_n < MAXEV) begin
      ex_kind[ex_n] = k; ex_adr[ex_n] = a; ex_dat[ex_n] = d; ex_tag[ex_n] = t;
      ex_n++;
    end
  endfunction

  // Bench interpreter of the command list (R1, R3-R6, R9)
  function automatic void build_expect(input int target);
    int pc;
    int steps;
    logic [31:0] acc;
    logic [31:0] w;
    logic [31:0] a;
    pc = 0; steps = 0; acc = '0; ex_n = 0;
    while (ex_n < target && steps < 100000) begin
      w = prog[pc];
      a = prog[(pc + 1) % DEPTH];
      steps++;
      case (w[31:28])
        4'h1: begin push(0, a, {4'h0, w[27:0]}, "R3"); pc = (pc + 2) % DEPTH; end
        4'h2: begin push(1, a, rd_fn(a), "R4"); acc = rd_fn(a); pc = (pc + 2) % DEPTH; end
        4'h3: begin push(0, a, acc, "R5"); pc = (pc + 2) % DEPTH; end
        4'h4: begin push(2, 32'h0, acc, "R6"); pc = (pc + 1) % DEPTH; end
        default: pc = (pc + 1) % DEPTH;
      endcase
    end
  endfunction

  // Slave model and monitor: decisions made at the falling edge
  always @(negedge clk_i) begin
    cyc_cnt++;
    if (!rst_ni) begin
      wb_ack_i = 1'b0; host_ready_i = 1'b0; in_acc = 0;
    end else begin
      wb_ack_i = 1'b0;
      if (wb_cyc_o && wb_stb_o) begin
        if (!in_acc) begin
          in_acc = 1; lat = int'($urandom_range(ack_lat_max, 0)); wait_n = 0; cur_rise = cyc_cnt;
        end
        if (wait_n == lat) begin
          wb_ack_i = 1'b1; in_acc = 0;
          record(wb_we_o ? 0 : 1, wb_adr_o, wb_we_o ? wb_dat_o : rd_fn(wb_adr_o), cur_rise, cyc_cnt);
        end else begin
          wait_n++;
        end
      end
      host_ready_i = (int'($urandom_range(99, 0)) < ready_pct);
      if (host_valid_o && host_ready_i) record(2, 32'h0, host_data_o, cyc_cnt, cyc_cnt);
    end
  end

  task automatic run_prog(input int target);
    int c;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk_i);
      prog_valid_i = 1'b1; prog_addr_i = PCW'(i); prog_data_i = prog[i];
    end
    @(negedge clk_i);
    prog_valid_i = 1'b0;
    check(!wb_cyc_o && !wb_stb_o && !host_valid_o, "R2", "outputs idle in reset",
          {61'd0, wb_cyc_o, wb_stb_o, host_valid_o}, 64'd0);
    check(prog_ready_o == 1'b1, "R10", "load port ready", {63'd0, prog_ready_o}, 64'd1);
    ob_n = 0;
    rst_ni = 1'b1;
    c = 0;
    while (ob_n < target && c < 4000) begin @(negedge clk_i); c++; end
    check(ob_n >= target, "R9", "events seen", 64'(ob_n), 64'(target));
    build_expect(target);
    for (int i = 0; i < target && i < ob_n; i++) begin
      check(ob_kind[i] == ex_kind[i] && ob_adr[i] == ex_adr[i] && ob_dat[i] == ex_dat[i],
            ex_tag[i], $sformatf("event %0d kind %0d/%0d", i, ob_kind[i], ex_kind[i]),
            {ob_adr[i], ob_dat[i]}, {ex_adr[i], ex_dat[i]});
    end
  endtask

  task automatic gen_random();
    int i;
    int r;
    i = 0;
    while (i < DEPTH - 1) begin
      r = int'($urandom_range(9, 0));
      if ((r >= 2 && r <= 5) || r == 9) begin
        if (i >= DEPTH - 2) r = 0;
      end
      case (r)
        1: begin prog[i] = {4'hA + 4'($urandom_range(5, 0)), 28'($urandom)}; i++; end
        2, 3: begin prog[i] = {4'h1, 28'($urandom)}; prog[i+1] = $urandom; i += 2; end
        4, 9: begin prog[i] = {4'h2, 28'($urandom)}; prog[i+1] = $urandom; i += 2; end
        5: begin prog[i] = {4'h3, 28'($urandom)}; prog[i+1] = $urandom; i += 2; end
        6, 7: begin prog[i] = {4'h4, 28'($urandom)}; i++; end
        8: begin prog[i] = {4'h8, 28'($urandom_range(6, 0))}; i++; end
        default: begin prog[i] = {4'h0, 28'($urandom)}; i++; end
      endcase
    end
    prog[DEPTH-1] = 32'h4000_0000;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    @(negedge clk_i);
    while (cyc_cnt < 150000 && !done) @(negedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=<150000", cyc_cnt);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));

    // Directed: every opcode, two passes, random latency and back-pressure
    prog[0]  = 32'h4000_0000;              // host: acc after reset (R2, R6)
    prog[1]  = 32'h1FFF_FFFF;              // write imm, zero extended (R3)
    prog[2]  = 32'h8000_0010;
    prog[3]  = 32'h5000_0000;              // unassigned -> no-op (R1)
    prog[4]  = 32'h2000_0000;              // read to acc (R4)
    prog[5]  = 32'h0000_1234;
    prog[6]  = 32'h3000_0ABC;              // write acc, imm ignored (R5)
    prog[7]  = 32'h0000_2000;
    prog[8]  = 32'hF000_0000;              // unassigned (R1)
    prog[9]  = 32'h4000_0001;
    prog[10] = 32'h0000_0000;
    prog[11] = 32'h8000_0003;              // pause (R7)
    prog[12] = 32'h2000_0000;
    prog[13] = 32'hC000_0000;
    prog[14] = 32'h3000_0000;
    prog[15] = 32'h0000_0004;              // address word in last slot, then wrap (R9)
    ack_lat_max = 3; ready_pct = 50;
    run_prog(14);

    // Directed timing: zero-latency acks, gaps between accesses
    for (int i = 0; i < DEPTH; i++) prog[i] = 32'h0000_0000;
    prog[0] = 32'h1000_0011; prog[1] = 32'h0000_0100;
    prog[2] = 32'h1000_0022; prog[3] = 32'h0000_0104;
    prog[4] = 32'h8000_0000;
    prog[5] = 32'h1000_0033; prog[6] = 32'h0000_0108;
    prog[7] = 32'h8000_0001;
    prog[8] = 32'h1000_0044; prog[9] = 32'h0000_010C;
    prog[10] = 32'h8000_0019;
    prog[11] = 32'h1000_0055; prog[12] = 32'h0000_0110;
    ack_lat_max = 0; ready_pct = 100;
    run_prog(6);
    if (ob_n >= 6) begin
      check(ob_rise[1] - ob_ack[0] == 3, "R8", "back-to-back gap", 64'(ob_rise[1] - ob_ack[0]), 64'd3);
      check(ob_rise[2] - ob_ack[1] == 4, "R7", "pause 0 gap", 64'(ob_rise[2] - ob_ack[1]), 64'd4);
      check(ob_rise[3] - ob_ack[2] == 5, "R7", "pause 1 gap", 64'(ob_rise[3] - ob_ack[2]), 64'd5);
      check(ob_rise[4] - ob_ack[3] == 29, "R7", "pause 25 gap", 64'(ob_rise[4] - ob_ack[3]), 64'd29);
      check(ob_rise[5] - ob_ack[4] == 6, "R1", "three no-ops then wrap gap", 64'(ob_rise[5] - ob_ack[4]), 64'd6);
    end

    // Host back-pressure with mostly-low ready
    for (int i = 0; i < DEPTH; i++) prog[i] = 32'h4000_0000;
    prog[2] = 32'h2000_0000; prog[3] = 32'h0000_00F0;
    ack_lat_max = 2; ready_pct = 15;
    run_prog(10);

    // Random programs
    for (int s = 0; s < 8; s++) begin
      gen_random();
      ack_lat_max = int'($urandom_range(4, 0));
      ready_pct = int'($urandom_range(100, 30));
      run_prog(20);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule